// File: doc/BRIEF.md
# DMA Request Cache-Line Splitter

This block sits between a DMA requester and a memory-side request queue that works in whole cache lines. The requester hands over one transfer at a time: a byte start address, a byte count, a direction and, for writes, the full payload. The block cuts the transfer into pieces that each stay inside one cache line. It sends them downstream one at a time, and it waits for each piece to be acknowledged (write) or answered with line data (read) before it sends the next one.

When the last piece has completed, the block returns a single response to the requester one cycle later. For reads, the response carries the gathered payload. While a transfer is in flight, any further request is refused. A requester that was refused receives a one-cycle retry strobe as soon as the engine is free again. A drain query reports whether the engine is empty, and it signals completion later if it was not.

Top module: `dma_line_splitter`

## Requirements
- R1: A request (`req_valid` high for one cycle) is accepted when the engine is idle, and `req_ack` pulses in the following cycle. A request that arrives while a transfer is in flight gets a `req_nack` pulse in the following cycle instead and is ignored: the pieces and the response of the active transfer are unchanged. `req_ack` and `req_nack` are never high together.
- R2: The first piece starts at the start address. Its length is the smaller of the total length and LINE_BYTES minus the start's byte offset within the line (address modulo LINE_BYTES).
- R3: Each later piece starts at the start address plus the bytes completed so far, which is line-aligned. Its length is the smaller of the remaining bytes and LINE_BYTES. No piece is issued after the total has been covered.
- R4: Only one piece is outstanding at a time. `dn_valid` holds its address and length stable until `dn_ready`, then drops. No new piece appears until a completion of the matching kind arrives: `dn_wack` for writes (`dn_write`=1), `dn_rvalid` for reads. A completion of the other kind is ignored.
- R5: On a write piece, `dn_wdata` byte lane k (bits 8k+7..8k) carries payload byte i, where i is the number of bytes done plus k minus the piece's offset. This holds for the lanes the piece covers, so lane k always corresponds to address line_base+k. Payload byte i of `req_wdata` sits at bits 8i+7..8i and belongs to address start+i.
- R6: For a read, `dn_rdata` lane k holds the byte at line_base+k. `rsp_rdata` byte i equals the byte at start+i for every i below the length. Lanes are taken from the start offset in the first piece and from lane 0 in later pieces.
- R7: One cycle after the final completion, `rsp_valid` pulses for one cycle if the request asked for a response (`req_need_rsp`=1), with `rsp_write` giving the direction. No pulse comes if it did not ask. The engine is already idle in the cycle right after the final completion, so a request presented then is acknowledged.
- R8: If any request was refused during a transfer, `retry_ok` pulses for exactly one cycle right after that transfer's final completion. Otherwise it stays low.
- R9: A drain query (`drain_req` pulse) on an idle engine gives a `drain_done` pulse in the next cycle. On a busy engine it raises `drain_wait` in the next cycle, and `drain_wait` stays high until the transfer finishes, when it drops and `drain_done` pulses.
- R10: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_need_rsp | input | 1 | Request wants a completion response |
| req_addr | input | ADDR_W | Byte start address |
| req_len | input | LEN_W | Byte count, 1..MAX_LEN |
| req_wdata | input | MAX_LEN*8 | Write payload, byte i for address start+i |
| req_ack | output | 1 | Request accepted |
| req_nack | output | 1 | Request refused, engine busy |
| retry_ok | output | 1 | Refused requester may retry now |
| dn_valid | output | 1 | Piece valid toward memory side |
| dn_ready | input | 1 | Memory side takes the piece |
| dn_write | output | 1 | Piece direction |
| dn_addr | output | ADDR_W | Piece byte address |
| dn_len | output | LEN_W | Piece byte count |
| dn_wdata | output | LINE_BYTES*8 | Write data in line lanes |
| dn_rvalid | input | 1 | Read data for the outstanding piece |
| dn_rdata | input | LINE_BYTES*8 | Read line data in line lanes |
| dn_wack | input | 1 | Write acknowledge for the outstanding piece |
| rsp_valid | output | 1 | Response to requester |
| rsp_write | output | 1 | Direction of the completed request |
| rsp_rdata | output | MAX_LEN*8 | Gathered read payload |
| drain_req | input | 1 | Drain query strobe |
| drain_wait | output | 1 | Drain pending behind an active transfer |
| drain_done | output | 1 | Engine is empty |

## Verification
A wrong byte counter shows up at the memory side at the next piece, as an address off its line boundary or a length past the line end. It also shows up at completion, as an early or missing response. A wrong lane offset corrupts write lanes at the first piece and read bytes at the response, one cycle after the last completion. A stuck busy or retry flag shows at the first refused or retried request: a missing `req_ack` right after completion, or a `retry_ok` that is absent, doubled or unprompted. The sweep covers every start offset against every length in both directions, so each of these shows within a few cycles of the request that exercises it.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SEND = 2'd1,
    PH_WAIT = 2'd2
  } phase_e;
endpackage

// File: rtl/dma_split_plan.sv
// Computes the next piece from start, total and bytes already covered.
module dma_split_plan #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 4,
  parameter int LEN_W      = 5,
  parameter int OFF_W      = 2
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  total_len,
  input  logic [LEN_W-1:0]  covered,
  output logic [ADDR_W-1:0] piece_addr,
  output logic [LEN_W-1:0]  piece_len,
  output logic [OFF_W-1:0]  piece_shift
);
  logic [LEN_W-1:0] room;
  logic [LEN_W-1:0] remain;

  always_comb begin
    piece_shift = (covered == '0) ? start_addr[OFF_W-1:0] : '0;
    room        = LEN_W'(LINE_BYTES) - LEN_W'(piece_shift);
    remain      = total_len - covered;
    piece_len   = (remain < room) ? remain : room;
    piece_addr  = start_addr + ADDR_W'(covered);
  end
endmodule

// File: rtl/dma_split_wlanes.sv
// Places payload bytes onto the line lanes a piece covers.
module dma_split_wlanes #(
  parameter int LINE_BYTES = 4,
  parameter int MAX_LEN    = 16,
  parameter int LEN_W      = 5,
  parameter int OFF_W      = 2
) (
  input  logic [MAX_LEN*8-1:0]    payload,
  input  logic [LEN_W-1:0]        base,
  input  logic [OFF_W-1:0]        shift,
  input  logic [LEN_W-1:0]        count,
  output logic [LINE_BYTES*8-1:0] lanes
);
  for (genvar k = 0; k < LINE_BYTES; k++) begin : g_lane
    logic [7:0] lane_byte;
    always_comb begin
      int src;
      lane_byte = 8'h00;
      src = int'(base) + k - int'(shift);
      if (k >= int'(shift) && k < int'(shift) + int'(count) &&
          src >= 0 && src < MAX_LEN)
        lane_byte = payload[src*8 +: 8];
    end
    assign lanes[k*8 +: 8] = lane_byte;
  end
endmodule

// File: rtl/dma_split_gather.sv
// Collects read bytes from each piece's line lanes into the response buffer.
module dma_split_gather #(
  parameter int LINE_BYTES = 4,
  parameter int MAX_LEN    = 16,
  parameter int LEN_W      = 5,
  parameter int OFF_W      = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    capture,
  input  logic [LINE_BYTES*8-1:0] line_data,
  input  logic [LEN_W-1:0]        base,
  input  logic [LEN_W-1:0]        count,
  input  logic [OFF_W-1:0]        shift,
  output logic [MAX_LEN*8-1:0]    buffer
);
  for (genvar j = 0; j < MAX_LEN; j++) begin : g_byte
    logic       hit;
    logic [7:0] pick;
    always_comb begin
      int lane;
      lane = j - int'(base) + int'(shift);
      hit  = (j >= int'(base)) && (j < int'(base) + int'(count)) &&
             (lane >= 0) && (lane < LINE_BYTES);
      pick = hit ? line_data[lane*8 +: 8] : 8'h00;
    end
    always_ff @(posedge clk) begin
      if (rst || clear)
        buffer[j*8 +: 8] <= 8'h00;
      else if (capture && hit)
        buffer[j*8 +: 8] <= pick;
    end
  end
endmodule

// File: rtl/dma_line_splitter.sv
module dma_line_splitter #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 4,
  parameter int MAX_LEN    = 16,
  parameter int LEN_W      = $clog2(MAX_LEN + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic                    req_need_rsp,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic [MAX_LEN*8-1:0]    req_wdata,
  output logic                    req_ack,
  output logic                    req_nack,
  output logic                    retry_ok,
  output logic                    dn_valid,
  input  logic                    dn_ready,
  output logic                    dn_write,
  output logic [ADDR_W-1:0]       dn_addr,
  output logic [LEN_W-1:0]        dn_len,
  output logic [LINE_BYTES*8-1:0] dn_wdata,
  input  logic                    dn_rvalid,
  input  logic [LINE_BYTES*8-1:0] dn_rdata,
  input  logic                    dn_wack,
  output logic                    rsp_valid,
  output logic                    rsp_write,
  output logic [MAX_LEN*8-1:0]    rsp_rdata,
  input  logic                    drain_req,
  output logic                    drain_wait,
  output logic                    drain_done
);
  import dma_split_pkg::*;

  localparam int OFF_W = $clog2(LINE_BYTES);

  phase_e              phase;
  logic                busy;
  logic [ADDR_W-1:0]   start_q;
  logic [LEN_W-1:0]    total_q;
  logic [LEN_W-1:0]    done_q;
  logic [LEN_W-1:0]    issued_q;
  logic                wr_q;
  logic                need_rsp_q;
  logic [MAX_LEN*8-1:0] wbuf_q;
  logic                retry_pend;
  logic                rsp_pend;

  logic                accept;
  logic                refuse;
  logic                piece_done;
  logic                finish;

  logic [ADDR_W-1:0]   p_start;
  logic [LEN_W-1:0]    p_total;
  logic [LEN_W-1:0]    p_covered;
  logic [MAX_LEN*8-1:0] p_payload;
  logic [ADDR_W-1:0]   nx_addr;
  logic [LEN_W-1:0]    nx_len;
  logic [OFF_W-1:0]    nx_shift;
  logic [LINE_BYTES*8-1:0] nx_lanes;

  logic [OFF_W-1:0]    rd_shift;
  logic [MAX_LEN*8-1:0] gathered;

  assign busy       = (phase != PH_IDLE);
  assign accept     = req_valid && !busy;
  assign refuse     = req_valid && busy;
  assign piece_done = (phase == PH_WAIT) && (wr_q ? dn_wack : dn_rvalid);
  assign finish     = piece_done && (issued_q == total_q);

  // While idle the plan looks at the incoming request; afterwards at the
  // latched request with everything issued so far counted as covered.
  assign p_start   = busy ? start_q  : req_addr;
  assign p_total   = busy ? total_q  : req_len;
  assign p_covered = busy ? issued_q : '0;
  assign p_payload = busy ? wbuf_q   : req_wdata;

  dma_split_plan #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W), .OFF_W(OFF_W)
  ) u_plan (
    .start_addr (p_start),
    .total_len  (p_total),
    .covered    (p_covered),
    .piece_addr (nx_addr),
    .piece_len  (nx_len),
    .piece_shift(nx_shift)
  );

  dma_split_wlanes #(
    .LINE_BYTES(LINE_BYTES), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .OFF_W(OFF_W)
  ) u_wlanes (
    .payload(p_payload),
    .base   (p_covered),
    .shift  (nx_shift),
    .count  (nx_len),
    .lanes  (nx_lanes)
  );

  assign rd_shift = (done_q == '0) ? start_q[OFF_W-1:0] : '0;

  dma_split_gather #(
    .LINE_BYTES(LINE_BYTES), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .OFF_W(OFF_W)
  ) u_gather (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .capture  (piece_done && !wr_q),
    .line_data(dn_rdata),
    .base     (done_q),
    .count    (issued_q - done_q),
    .shift    (rd_shift),
    .buffer   (gathered)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      start_q    <= '0;
      total_q    <= '0;
      done_q     <= '0;
      issued_q   <= '0;
      wr_q       <= 1'b0;
      need_rsp_q <= 1'b0;
      wbuf_q     <= '0;
      dn_valid   <= 1'b0;
      dn_write   <= 1'b0;
      dn_addr    <= '0;
      dn_len     <= '0;
      dn_wdata   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            start_q    <= req_addr;
            total_q    <= req_len;
            wr_q       <= req_write;
            need_rsp_q <= req_need_rsp;
            wbuf_q     <= req_wdata;
            done_q     <= '0;
            issued_q   <= nx_len;
            dn_valid   <= 1'b1;
            dn_write   <= req_write;
            dn_addr    <= nx_addr;
            dn_len     <= nx_len;
            dn_wdata   <= nx_lanes;
            phase      <= PH_SEND;
          end
        end
        PH_SEND: begin
          if (dn_ready) begin
            dn_valid <= 1'b0;
            phase    <= PH_WAIT;
          end
        end
        PH_WAIT: begin
          if (piece_done) begin
            done_q <= issued_q;
            if (finish) begin
              phase <= PH_IDLE;
            end else begin
              issued_q <= issued_q + nx_len;
              dn_valid <= 1'b1;
              dn_addr  <= nx_addr;
              dn_len   <= nx_len;
              dn_wdata <= nx_lanes;
              phase    <= PH_SEND;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Requester-side strobes, response and drain signalling.
  always_ff @(posedge clk) begin
    if (rst) begin
      req_ack    <= 1'b0;
      req_nack   <= 1'b0;
      retry_pend <= 1'b0;
      retry_ok   <= 1'b0;
      rsp_pend   <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_write  <= 1'b0;
      rsp_rdata  <= '0;
      drain_wait <= 1'b0;
      drain_done <= 1'b0;
    end else begin
      req_ack    <= accept;
      req_nack   <= refuse;
      retry_ok   <= finish && (retry_pend || refuse);
      retry_pend <= (retry_pend || refuse) && !finish;
      rsp_pend   <= finish && need_rsp_q;
      rsp_valid  <= rsp_pend;
      if (rsp_pend) begin
        rsp_rdata <= gathered;
        rsp_write <= wr_q;
      end
      drain_done <= (drain_req && (!busy || finish)) || (drain_wait && finish);
      drain_wait <= (drain_wait || (drain_req && busy)) && !finish;
    end
  end
endmodule

// File: rtl/dma_split_chk.sv
module dma_split_chk #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 4,
  parameter int LEN_W      = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ack,
  input logic              req_nack,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic [ADDR_W-1:0] dn_addr,
  input logic [LEN_W-1:0]  dn_len,
  input logic              rsp_valid,
  input logic              retry_ok,
  input logic              busy
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic later;
  always_ff @(posedge clk) begin
    if (rst)
      later <= 1'b0;
    else if (req_ack)
      later <= dn_valid && dn_ready;
    else if (dn_valid && dn_ready)
      later <= 1'b1;
  end

  a_r1_refuse_busy: assert property (@(posedge clk) disable iff (rst)
    req_valid && busy |=> req_nack && !req_ack);

  a_r1_ack_nack_excl: assert property (@(posedge clk) disable iff (rst)
    !(req_ack && req_nack));

  a_r2_piece_in_line: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> (dn_len != '0) &&
                 (int'(dn_addr[OFF_W-1:0]) + int'(dn_len) <= LINE_BYTES));

  a_r3_later_aligned: assert property (@(posedge clk) disable iff (rst)
    dn_valid && later && !req_ack |-> dn_addr[OFF_W-1:0] == '0);

  a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_len));

  a_r4_valid_needs_busy: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> busy);

  a_r7_rsp_after_idle: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(!busy));

  a_r8_retry_single: assert property (@(posedge clk) disable iff (rst)
    retry_ok |=> !retry_ok);
endmodule

bind dma_line_splitter dma_split_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ack  (req_ack),
  .req_nack (req_nack),
  .dn_valid (dn_valid),
  .dn_ready (dn_ready),
  .dn_addr  (dn_addr),
  .dn_len   (dn_len),
  .rsp_valid(rsp_valid),
  .retry_ok (retry_ok),
  .busy     (busy)
);

// File: tb/dma_line_splitter_test.sv
`timescale 1ns/1ps
module dma_line_splitter_test;
  localparam int AW = 16;
  localparam int LB = 4;
  localparam int ML = 16;
  localparam int LW = $clog2(ML + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0, req_need_rsp = 0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [ML*8-1:0] req_wdata = '0;
  logic req_ack, req_nack, retry_ok;
  logic dn_valid, dn_write;
  logic dn_ready = 0;
  logic [AW-1:0] dn_addr;
  logic [LW-1:0] dn_len;
  logic [LB*8-1:0] dn_wdata;
  logic dn_rvalid = 0, dn_wack = 0;
  logic [LB*8-1:0] dn_rdata = '0;
  logic rsp_valid, rsp_write;
  logic [ML*8-1:0] rsp_rdata;
  logic drain_req = 0;
  logic drain_wait, drain_done;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  dma_line_splitter #(.ADDR_W(AW), .LINE_BYTES(LB), .MAX_LEN(ML)) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_need_rsp(req_need_rsp),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .req_ack(req_ack), .req_nack(req_nack), .retry_ok(retry_ok),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_len(dn_len), .dn_wdata(dn_wdata),
    .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata), .dn_wack(dn_wack),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_rdata(rsp_rdata),
    .drain_req(drain_req), .drain_wait(drain_wait), .drain_done(drain_done)
  );

  function automatic logic [7:0] mem_byte(int a);
    return 8'((a * 37 + 11) ^ (a >> 8));
  endfunction

  function automatic logic [7:0] pay_byte(int seed, int i);
    return 8'(seed * 13 + i * 29 + 3);
  endfunction

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic issue(int addr, int len, bit wr, bit nr, int seed);
    req_valid    = 1'b1;
    req_addr     = AW'(addr);
    req_len      = LW'(len);
    req_write    = wr;
    req_need_rsp = nr;
    for (int i = 0; i < ML; i++) req_wdata[i*8 +: 8] = pay_byte(seed, i);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ack === 1'b1 && req_nack === 1'b0, "R1", "accept when idle",
        {req_ack, req_nack}, 2'b10);
  endtask

  task automatic serve(int addr, int len, bit wr, bit nr, int seed,
                       bit inj_refuse, bit inj_drain, bit chain,
                       int next_addr, int next_len);
    int done = 0;
    bit first = 1;
    while (done < len) begin
      int off   = first ? (addr % LB) : 0;
      int room  = LB - off;
      int clen  = (len - done < room) ? (len - done) : room;
      int caddr = addr + done;
      int lbase = caddr - off;
      int guard = 0;
      while (dn_valid !== 1'b1 && guard < 40) begin
        @(negedge clk);
        guard++;
      end
      chk(dn_valid === 1'b1, "R4", "piece presented", dn_valid, 1);
      chk(dn_addr === AW'(caddr), first ? "R2" : "R3", "piece address", dn_addr, caddr);
      chk(dn_len === LW'(clen), first ? "R2" : "R3", "piece length", dn_len, clen);
      chk(dn_write === wr, "R4", "piece direction", dn_write, wr);
      if (wr) begin
        for (int k = off; k < off + clen; k++)
          chk(dn_wdata[k*8 +: 8] === pay_byte(seed, done + k - off), "R5",
              "write lane", dn_wdata[k*8 +: 8], pay_byte(seed, done + k - off));
      end
      for (int s = 0; s < (caddr + len) % 3; s++) begin
        @(negedge clk);
        chk(dn_valid === 1'b1 && dn_addr === AW'(caddr), "R4", "hold until ready",
            dn_addr, caddr);
      end
      dn_ready = 1'b1;
      @(negedge clk);
      dn_ready = 1'b0;
      chk(dn_valid === 1'b0, "R4", "drop after ready", dn_valid, 0);
      if (inj_refuse && first) begin
        req_valid = 1'b1;
        req_addr  = AW'(addr + 100);
        req_len   = LW'(1);
        req_write = ~wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_nack === 1'b1 && req_ack === 1'b0, "R1", "refuse when busy",
            {req_ack, req_nack}, 2'b01);
      end
      if (inj_drain && first) begin
        drain_req = 1'b1;
        @(negedge clk);
        drain_req = 1'b0;
        chk(drain_wait === 1'b1 && drain_done === 1'b0, "R9", "drain waits",
            {drain_wait, drain_done}, 2'b10);
      end
      if (wr) begin
        dn_rvalid = 1'b1;
        @(negedge clk);
        dn_rvalid = 1'b0;
        chk(dn_valid === 1'b0, "R4", "wrong completion kind ignored", dn_valid, 0);
      end
      for (int s = 0; s < caddr % 2; s++) begin
        @(negedge clk);
        chk(dn_valid === 1'b0, "R4", "no piece before completion", dn_valid, 0);
      end
      for (int k = 0; k < LB; k++) dn_rdata[k*8 +: 8] = mem_byte(lbase + k);
      if (wr) dn_wack = 1'b1; else dn_rvalid = 1'b1;
      @(negedge clk);
      dn_wack = 1'b0;
      dn_rvalid = 1'b0;
      done += clen;
      first = 0;
    end
    chk(dn_valid === 1'b0, "R3", "no piece past total", dn_valid, 0);
    chk(retry_ok === inj_refuse, "R8", "retry strobe at finish", retry_ok, inj_refuse);
    chk(drain_done === inj_drain && drain_wait === 1'b0, "R9", "drain done at finish",
        {drain_done, drain_wait}, {inj_drain, 1'b0});
    chk(rsp_valid === 1'b0, "R7", "response not yet", rsp_valid, 0);
    if (chain) begin
      req_valid    = 1'b1;
      req_addr     = AW'(next_addr);
      req_len      = LW'(next_len);
      req_write    = 1'b0;
      req_need_rsp = 1'b1;
    end
    @(negedge clk);
    if (chain) begin
      req_valid = 1'b0;
      chk(req_ack === 1'b1 && req_nack === 1'b0, "R7", "accept right after finish",
          {req_ack, req_nack}, 2'b10);
    end
    chk(retry_ok === 1'b0, "R8", "retry one cycle", retry_ok, 0);
    chk(rsp_valid === nr, "R7", "response strobe", rsp_valid, nr);
    if (nr) begin
      chk(rsp_write === wr, "R7", "response direction", rsp_write, wr);
      if (!wr) begin
        for (int i = 0; i < len; i++)
          chk(rsp_rdata[i*8 +: 8] === mem_byte(addr + i), "R6", "read byte",
              rsp_rdata[i*8 +: 8], mem_byte(addr + i));
      end
    end
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R7", "response one cycle", rsp_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk({req_ack, req_nack, retry_ok, dn_valid, rsp_valid, drain_wait, drain_done} === 7'b0,
        "R10", "outputs after reset",
        {req_ack, req_nack, retry_ok, dn_valid, rsp_valid, drain_wait, drain_done}, 0);

    // R9: drain query on idle engine
    drain_req = 1'b1;
    @(negedge clk);
    drain_req = 1'b0;
    chk(drain_done === 1'b1 && drain_wait === 1'b0, "R9", "idle drain",
        {drain_done, drain_wait}, 2'b10);
    @(negedge clk);
    chk(drain_done === 1'b0, "R9", "idle drain one cycle", drain_done, 0);

    // Sweep: every offset, every length, both directions
    for (int wr = 0; wr < 2; wr++) begin
      for (int off = 0; off < LB; off++) begin
        for (int len = 1; len <= ML; len++) begin
          int addr = 16'h0200 + off + len * 64 + wr * 4096;
          bit nr = (len % 5 != 0);
          bit rf = (len == 7 || len == 2);
          bit dr = (len == 9 || len == 2);
          int seed = off * 31 + len + wr * 7;
          issue(addr, len, bit'(wr), nr, seed);
          serve(addr, len, bit'(wr), nr, seed, rf, dr, 1'b0, 0, 0);
        end
      end
    end

    // R7: back-to-back acceptance in the cycle after the final completion
    issue(16'h0301, 6, 1'b0, 1'b1, 5);
    serve(16'h0301, 6, 1'b0, 1'b1, 5, 1'b1, 1'b0, 1'b1, 16'h0402, 3);
    serve(16'h0402, 3, 1'b0, 1'b1, 0, 1'b0, 1'b0, 1'b0, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule